// File: doc/BRIEF.md
# Spiking Crossbar Bus Front End

This block sits between a 32-bit Wishbone classic master and a 256-axon by 256-neuron spiking crossbar. Bus writes load the crossbar's configuration: a binary synapse matrix with one 256-bit row per axon, and one 80-bit parameter word per neuron. The integrate-and-fire arithmetic lives elsewhere. This block only decodes the bus, holds the storage and produces events.

Some bus reads are commands rather than data reads. A read at the start of a synapse row injects an input packet for that axon. The event carries the axon index and the full stored row, so the crossbar can apply it in one step. Reads of two marker addresses signal the start and the end of an image's packet stream. All events leave on a single valid / kind / axon / row interface. Every bus access is acknowledged, whatever its address.

Top module: `spike_xbar_wb_frontend`

## Requirements
- R1: Every access (cyc and stb high while ack is low) is answered by ack high for exactly one cycle, in the cycle after the request is first sampled. This holds for any address, mapped or not.
- R2: A write to 0x30000000 + row*32 + seg*4 (row 0..255, seg 0..7) stores data byte b into synapse bits seg*32 + b*8 + 7 .. seg*32 + b*8 of that row, but only for the lanes b where sel[b] is 1. Word 0 therefore holds the least significant 32 bits of the row.
- R3: A read of 0x30000000 + axon*32 (byte offset within the row is zero) produces one event in the ack cycle. The event has evtValid=1, evtKind=0 (axon), evtAxon=axon and evtRow equal to the stored row. dat_o is zero for this read.
- R4: A write to 0x30004000 + n*16 + k*4 (n 0..255, k 0..2) stores byte lane b of the data, when sel[b] is 1, into parameter bits k*32 + b*8 upward. Lanes that fall at or above bit 80 are discarded, so bytes 2 and 3 of the word at +8 are dropped.
- R5: A read of 0x30004000 + n*16 + k*4 returns parameter bits [k*32 +: 32] for k 0..1. For k=2 it returns bits 79:64 in the low half and zero above. For k=3 it returns zero. None of these reads produces an event.
- R6: A read of 0x3000C001 produces a one-cycle event with evtKind=1 (new image). A read of 0x3000C003 produces one with evtKind=2 (last image). Both return zero on dat_o.
- R7: Writes to the marker addresses, to the reserved spike region at 0x30008000, or to any address outside the two tables are acknowledged. They raise no event and change no stored bit.
- R8: Reads that are neither parameter reads nor event reads return zero with no event. This covers synapse addresses with a non-zero offset in the row, the reserved region, 0x3000C002 and unmapped space. dat_o is also zero in every cycle without ack.
- R9: Synchronous active-high reset clears ack, evtValid and dat_o. Synapse and parameter contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wbCycI | input | 1 | Bus cycle |
| wbStbI | input | 1 | Bus strobe |
| wbWeI | input | 1 | Write enable |
| wbSelI | input | 4 | Byte lane enables |
| wbAdrI | input | 32 | Byte address |
| wbDatI | input | 32 | Write data |
| wbAckO | output | 1 | Acknowledge |
| wbDatO | output | 32 | Read data |
| evtValid | output | 1 | Event strobe |
| evtKind | output | 2 | 0 axon, 1 new image, 2 last image |
| evtAxon | output | 8 | Axon index of an axon event |
| evtRow | output | 256 | Synapse row of the injected axon |

## Verification
The in-RTL properties check the following on every cycle:
- the one-cycle handshake;
- that an event never appears without an ack;
- that the event kind is legal;
- that dat_o is zero both when the bus is idle and during an axon injection.

Only the bench's scenarios can show that stored contents are right. It fills the whole synapse matrix and the parameter table with computed patterns and injects every axon. It sweeps all sixteen byte-enable patterns on both tables. It checks that writes to ignored addresses and a mid-run reset leave the tables untouched.

// File: rtl/xbar_wb_pkg.sv
package xbar_wb_pkg;

  typedef enum logic [1:0] {
    EVT_AXON       = 2'd0,
    EVT_NEW_IMAGE  = 2'd1,
    EVT_LAST_IMAGE = 2'd2
  } evt_kind_e;

  localparam logic [31:0] SYN_BASE  = 32'h3000_0000;
  localparam logic [31:0] PAR_BASE  = 32'h3000_4000;
  localparam logic [31:0] MARK_NEW  = 32'h3000_C001;
  localparam logic [31:0] MARK_LAST = 32'h3000_C003;
  localparam int          PAR_STRIDE_SH = 4;

  // Strobes from control to datapath, one access at most per cycle.
  typedef struct packed {
    logic        synWr;
    logic        parWr;
    logic        synInject;
    logic        parRd;
    logic [31:0] offset;
  } dp_cmd_t;

endpackage

// File: rtl/xbar_wb_ctrl.sv
module xbar_wb_ctrl
  import xbar_wb_pkg::*;
#(
  parameter int SYN_ROWS = 256,
  parameter int SYN_COLS = 256,
  parameter int NEURONS  = 256,
  localparam int AXON_W  = $clog2(SYN_ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc,
  input  logic              stb,
  input  logic              we,
  input  logic [31:0]       adr,
  output dp_cmd_t           cmd,
  output logic              ackO,
  output logic              evtValid,
  output evt_kind_e         evtKind,
  output logic [AXON_W-1:0] evtAxon
);
  localparam int ROW_BYTES = SYN_COLS / 8;
  localparam int ROW_SH    = $clog2(ROW_BYTES);
  localparam logic [31:0] SYN_END = SYN_BASE + 32'(SYN_ROWS * ROW_BYTES);
  localparam logic [31:0] PAR_END = PAR_BASE + 32'(NEURONS << PAR_STRIDE_SH);

  logic        req, inSyn, inPar, rowStart, newHit, lastHit;
  logic [31:0] synOff, parOff;

  always_comb begin
    req      = cyc && stb && !ackO;
    synOff   = adr - SYN_BASE;
    parOff   = adr - PAR_BASE;
    inSyn    = (adr >= SYN_BASE) && (adr < SYN_END);
    inPar    = (adr >= PAR_BASE) && (adr < PAR_END);
    rowStart = (synOff[ROW_SH-1:0] == '0);
    newHit   = req && !we && (adr == MARK_NEW);
    lastHit  = req && !we && (adr == MARK_LAST);
    cmd.synWr     = req && we && inSyn;
    cmd.parWr     = req && we && inPar;
    cmd.synInject = req && !we && inSyn && rowStart;
    cmd.parRd     = req && !we && inPar;
    cmd.offset    = inPar ? parOff : synOff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ackO     <= 1'b0;
      evtValid <= 1'b0;
      evtKind  <= EVT_AXON;
      evtAxon  <= '0;
    end else begin
      ackO     <= req;
      evtValid <= cmd.synInject || newHit || lastHit;
      if (cmd.synInject) begin
        evtKind <= EVT_AXON;
        evtAxon <= synOff[ROW_SH +: AXON_W];
      end else if (newHit) begin
        evtKind <= EVT_NEW_IMAGE;
        evtAxon <= '0;
      end else if (lastHit) begin
        evtKind <= EVT_LAST_IMAGE;
        evtAxon <= '0;
      end
    end
  end

  assert_ack_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    (cyc && stb && !ackO) |=> ackO);
  assert_ack_has_req_R1: assert property (@(posedge clk) disable iff (rst)
    ackO |-> $past(cyc && stb));
  assert_evt_with_ack_R3: assert property (@(posedge clk) disable iff (rst)
    evtValid |-> ackO);
  assert_evt_kind_legal_R6: assert property (@(posedge clk) disable iff (rst)
    evtValid |-> (evtKind != 2'd3));

endmodule

// File: rtl/xbar_wb_datapath.sv
module xbar_wb_datapath
  import xbar_wb_pkg::*;
#(
  parameter int SYN_ROWS = 256,
  parameter int SYN_COLS = 256,
  parameter int NEURONS  = 256,
  parameter int PARAM_W  = 80
) (
  input  logic                clk,
  input  logic                rst,
  input  dp_cmd_t             cmd,
  input  logic [31:0]         wrData,
  input  logic [3:0]          sel,
  output logic [31:0]         rdData,
  output logic [SYN_COLS-1:0] evtRow
);
  localparam int SEGS      = SYN_COLS / 32;
  localparam int SEG_W     = (SEGS > 1) ? $clog2(SEGS) : 1;
  localparam int ROW_W     = $clog2(SYN_ROWS);
  localparam int ROW_SH    = $clog2(SYN_COLS / 8);
  localparam int NEU_W     = $clog2(NEURONS);
  localparam int PAR_WORDS = (PARAM_W + 31) / 32;
  localparam int PAR_PAD   = PAR_WORDS * 32;
  localparam logic [PAR_PAD-1:0] PAR_MASK = PAR_PAD'({PARAM_W{1'b1}});

  logic [SYN_COLS-1:0] synMem [SYN_ROWS];
  logic [PAR_PAD-1:0]  parMem [NEURONS];

  logic [ROW_W-1:0]   rowIdx;
  logic [SEG_W-1:0]   segIdx;
  logic [NEU_W-1:0]   neuIdx;
  logic [1:0]         wordIdx;
  logic               wordOk;
  logic [PAR_PAD-1:0] parSel;
  logic [3:0]         synLaneWe, parLaneWe;

  always_comb begin
    rowIdx  = cmd.offset[ROW_SH +: ROW_W];
    segIdx  = (SEGS > 1) ? SEG_W'(cmd.offset[ROW_SH-1:2]) : '0;
    neuIdx  = cmd.offset[PAR_STRIDE_SH +: NEU_W];
    wordIdx = cmd.offset[3:2];
    wordOk  = (32'(wordIdx) < PAR_WORDS);
    parSel  = parMem[neuIdx] & PAR_MASK;
  end

  // Per-lane write enables; parameter lanes beyond the word width are dropped.
  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign synLaneWe[b] = cmd.synWr && sel[b];
    assign parLaneWe[b] = cmd.parWr && sel[b] && wordOk &&
                          ((32'(wordIdx) * 32 + b * 8) < PARAM_W);
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < 4; b++) begin
      if (synLaneWe[b])
        synMem[rowIdx][32'(segIdx) * 32 + b * 8 +: 8] <= wrData[b*8 +: 8];
      if (parLaneWe[b])
        parMem[neuIdx][32'(wordIdx) * 32 + b * 8 +: 8] <= wrData[b*8 +: 8];
    end
    if (cmd.synInject) evtRow <= synMem[rowIdx];
  end

  always_ff @(posedge clk) begin
    if (rst)                     rdData <= '0;
    else if (cmd.parRd && wordOk) rdData <= parSel[32'(wordIdx) * 32 +: 32];
    else                         rdData <= '0;
  end

endmodule

// File: rtl/spike_xbar_wb_frontend.sv
module spike_xbar_wb_frontend
  import xbar_wb_pkg::*;
#(
  parameter int SYN_ROWS = 256,
  parameter int SYN_COLS = 256,
  parameter int NEURONS  = 256,
  parameter int PARAM_W  = 80,
  localparam int AXON_W  = $clog2(SYN_ROWS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wbCycI,
  input  logic                wbStbI,
  input  logic                wbWeI,
  input  logic [3:0]          wbSelI,
  input  logic [31:0]         wbAdrI,
  input  logic [31:0]         wbDatI,
  output logic                wbAckO,
  output logic [31:0]         wbDatO,
  output logic                evtValid,
  output logic [1:0]          evtKind,
  output logic [AXON_W-1:0]   evtAxon,
  output logic [SYN_COLS-1:0] evtRow
);
  dp_cmd_t   cmd;
  evt_kind_e kindInt;

  xbar_wb_ctrl #(.SYN_ROWS(SYN_ROWS), .SYN_COLS(SYN_COLS), .NEURONS(NEURONS)) u_ctrl (
    .clk(clk), .rst(rst), .cyc(wbCycI), .stb(wbStbI), .we(wbWeI), .adr(wbAdrI),
    .cmd(cmd), .ackO(wbAckO), .evtValid(evtValid), .evtKind(kindInt), .evtAxon(evtAxon)
  );

  xbar_wb_datapath #(.SYN_ROWS(SYN_ROWS), .SYN_COLS(SYN_COLS), .NEURONS(NEURONS),
                     .PARAM_W(PARAM_W)) u_dp (
    .clk(clk), .rst(rst), .cmd(cmd), .wrData(wbDatI), .sel(wbSelI),
    .rdData(wbDatO), .evtRow(evtRow)
  );

  assign evtKind = kindInt;

  assert_inject_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (evtValid && evtKind == 2'd0) |-> (wbDatO == '0));
  assert_idle_bus_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !wbAckO |-> (wbDatO == '0));

endmodule

// File: tb/spike_xbar_wb_frontend_tb.sv
module spike_xbar_wb_frontend_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SYN_B = 32'h3000_0000;
  localparam logic [31:0] PAR_B = 32'h3000_4000;

  logic clk = 1'b0, rst = 1'b1;
  logic cyc = 0, stb = 0, we = 0;
  logic [3:0] sel = 0;
  logic [31:0] adr = 0, dat = 0;
  logic ack, evV;
  logic [31:0] datO;
  logic [1:0] evK;
  logic [7:0] evA;
  logic [255:0] evR;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [255:0] expSyn [256];
  logic [95:0]  expPar [256];

  // Results of the latest access
  logic [31:0] rRd; logic rPre, rAck, rEv; logic [1:0] rKind; logic [7:0] rAx; logic [255:0] rRow;

  spike_xbar_wb_frontend u_dut (
    .clk(clk), .rst(rst), .wbCycI(cyc), .wbStbI(stb), .wbWeI(we), .wbSelI(sel),
    .wbAdrI(adr), .wbDatI(dat), .wbAckO(ack), .wbDatO(datO), .evtValid(evV),
    .evtKind(evK), .evtAxon(evA), .evtRow(evR)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] synWord(input int r, input int s);
    return {8'(r) ^ 8'h5A, 8'(s), ~8'(r), 8'(r * 7 + s * 13)};
  endfunction

  function automatic logic [31:0] parWord(input int n, input int w);
    return {8'(n), 8'(w) ^ 8'hA5, 8'(n) ^ 8'hC3, 8'h96 ^ 8'(n + w)};
  endfunction

  task automatic access(input logic w, input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    cyc = 1; stb = 1; we = w; adr = a; dat = d; sel = s;
    #1 rPre = ack;
    @(negedge clk);
    rAck = ack; rRd = datO; rEv = evV; rKind = evK; rAx = evA; rRow = evR;
    cyc = 0; stb = 0; we = 0; sel = 0;
  endtask

  task automatic handshake(input string tag);
    chk(!rPre && rAck, tag, {rPre, rAck}, 2'b01);
  endtask

  task automatic synWrite(input int r, input int s, input logic [31:0] d, input logic [3:0] sl);
    access(1'b1, SYN_B + 32'(r * 32 + s * 4), d, sl);
    for (int b = 0; b < 4; b++)
      if (sl[b]) expSyn[r][s*32 + b*8 +: 8] = d[b*8 +: 8];
    handshake("R1 write ack");
    chk(!rEv, "R7 synapse write raises no event", rEv, 0);
  endtask

  task automatic parWrite(input int n, input int w, input logic [31:0] d, input logic [3:0] sl);
    access(1'b1, PAR_B + 32'(n * 16 + w * 4), d, sl);
    for (int b = 0; b < 4; b++)
      if (sl[b] && (w * 32 + b * 8) < 80) expPar[n][w*32 + b*8 +: 8] = d[b*8 +: 8];
    handshake("R1 write ack");
  endtask

  task automatic inject(input int r, input string tag);
    access(1'b0, SYN_B + 32'(r * 32), 32'h0, 4'hF);
    handshake("R1 inject ack");
    chk(rEv && rKind == 2'd0 && rAx == 8'(r) && rRd == 0, {tag, " R3 axon event"},
        {rEv, rKind, rAx, rRd}, {1'b1, 2'd0, 8'(r), 32'h0});
    chk(rRow == expSyn[r], {tag, " R3/R2 event row"}, rRow, expSyn[r]);
  endtask

  task automatic parRead(input int n, input int w, input string tag);
    logic [31:0] e;
    e = (w < 3) ? expPar[n][w*32 +: 32] : 32'h0;
    access(1'b0, PAR_B + 32'(n * 16 + w * 4), 32'h0, 4'hF);
    handshake("R1 read ack");
    chk(rRd == e && !rEv, {tag, " R5 parameter read"}, {rEv, rRd}, {1'b0, e});
  endtask

  task automatic quietRead(input logic [31:0] a, input string tag);
    access(1'b0, a, 32'h0, 4'hF);
    handshake("R1 read ack");
    chk(rRd == 0 && !rEv, {tag, " R8 plain read"}, {rEv, rRd}, 0);
  endtask

  task automatic quietWrite(input logic [31:0] a, input string tag);
    access(1'b1, a, 32'hDEAD_BEEF, 4'hF);
    handshake("R1 ignored-write ack");
    chk(!rEv, {tag, " R7 no event"}, rEv, 0);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin expSyn[i] = '0; expPar[i] = '0; end
    repeat (4) @(negedge clk);
    chk(!ack && !evV && datO == 0, "R9 reset outputs", {ack, evV, datO}, 0);
    rst = 0;

    // Fill the whole synapse matrix, then inject every axon.
    for (int r = 0; r < 256; r++)
      for (int s = 0; s < 8; s++) synWrite(r, s, synWord(r, s), 4'hF);
    for (int r = 0; r < 256; r++) inject(r, "sweep");

    // Byte-enable sweep on one synapse word.
    for (int s = 0; s < 16; s++) begin
      synWrite(200, 5, 32'h1111_1111 * (s + 1), 4'(s));
      inject(200, "R2 sel sweep");
    end
    synWrite(17, 3, 32'hFFFF_FFFF, 4'b0101);
    inject(17, "R2 partial");

    // Parameter table fill with full sel; upper half of word 2 must drop.
    for (int n = 0; n < 256; n++)
      for (int w = 0; w < 3; w++) parWrite(n, w, parWord(n, w), 4'hF);
    for (int n = 0; n < 256; n++)
      for (int w = 0; w < 4; w++) parRead(n, w, "R4 sweep");

    for (int s = 0; s < 16; s++) begin
      parWrite(9, 1, 32'h0102_0304 * (s + 3), 4'(s));
      parRead(9, 1, "R4 sel word1");
      parWrite(9, 2, 32'hF0E1_D2C3 ^ 32'(s), 4'(s));
      parRead(9, 2, "R4 sel word2");
    end
    parWrite(9, 3, 32'hFFFF_FFFF, 4'hF);
    parRead(9, 3, "R5 word3");
    parRead(9, 2, "R4 word3 write dropped");

    // Markers (R6).
    access(1'b0, 32'h3000_C001, 0, 4'hF);
    handshake("R1 marker ack");
    chk(rEv && rKind == 2'd1 && rRd == 0, "R6 new image", {rEv, rKind, rRd}, {1'b1, 2'd1, 32'h0});
    access(1'b0, 32'h3000_C003, 0, 4'hF);
    handshake("R1 marker ack");
    chk(rEv && rKind == 2'd2 && rRd == 0, "R6 last image", {rEv, rKind, rRd}, {1'b1, 2'd2, 32'h0});

    // Ignored writes (R7), then show storage unchanged.
    quietWrite(32'h3000_C001, "marker new");
    quietWrite(32'h3000_C003, "marker last");
    quietWrite(32'h3000_8000, "reserved");
    quietWrite(32'h3000_5000, "past param table");
    quietWrite(32'h3000_2000, "past synapse matrix");
    quietWrite(32'h1234_5678, "unmapped");
    quietWrite(32'h2FFF_FFFC, "below base");
    for (int n = 0; n < 256; n++) parRead(n, 0, "R7 table intact");
    for (int r = 0; r < 256; r += 17) inject(r, "R7 matrix intact");

    // Plain reads (R8).
    quietRead(SYN_B + 32'(5 * 32 + 4), "synapse mid-row");
    quietRead(SYN_B + 32'(5 * 32 + 1), "synapse odd byte");
    quietRead(32'h3000_8000, "reserved");
    quietRead(32'h3000_C002, "between markers");
    quietRead(32'h1234_5678, "unmapped");

    // Mid-run reset keeps contents (R9).
    @(negedge clk); rst = 1;
    @(negedge clk);
    @(negedge clk);
    chk(!ack && !evV && datO == 0, "R9 reset outputs mid-run", {ack, evV, datO}, 0);
    rst = 0;
    inject(42, "R9 after reset");
    parRead(42, 0, "R9 after reset");
    parRead(42, 2, "R9 after reset");

    summary();
  end
endmodule